// File: doc/BRIEF.md
# Grouped Interrupt Aggregator with Deferred Arrivals

This block gathers a group of level-sensitive interrupt source lines into one interrupt line toward a CPU-side controller. A source counts only when its line rises and its bit is set in an accumulated enable word. The block then reports the enabled, asserted sources to firmware through a status register. While firmware is busy with earlier sources, new arrivals are parked in a hidden pending word instead of overwriting status. When firmware has acknowledged every status bit, the pending arrivals are moved into status and the output is raised again.

The enable register has two jobs. A write that adds new bits grows the accumulated enable word. A write that adds no new bits is read as a mask or unmask request, which firmware uses around its service routines. The status register is write-one-to-clear. A write of all ones is an initialisation that replays nothing. A write of zero is refused and flagged with a one-cycle error pulse. All state changes at the clock edge. When a register write and a source edge fall in the same cycle, the write takes effect first.

Top module: `grp_irq_agg`

## Requirements
- R1: After reset the status and stored enable values read as zero, the output and error pulse are low, and the accumulated enable, mask and pending words are empty.
- R2: An arrival happens only in a cycle where at least one source line goes from 0 to 1. Its select word is the set of currently high lines ANDed with the accumulated enable word. A falling line, or an arrival whose select word is zero, changes nothing.
- R3: If an arrival with a nonzero select word finds both the mask word and the status register at zero, status is loaded with the select word and the output goes high on the next clock edge.
- R4: If an arrival with a nonzero select word finds the mask word or the status register nonzero, the select bits are ORed into the pending word, and status and output stay as they were.
- R5: A write to the enable register (byte offset 0x0) ORs its data into the accumulated enable word. A zero write while that word is empty, or a write that adds new bits, just stores the data, which is then what reads return.
- R6: An enable write that adds no new bits forms change = stored value XOR data. If change AND data is nonzero, the changed bits are cleared from the mask word. Otherwise they are set in the mask word. The data is then stored.
- R7: A write of zero to the status register (byte offset 0x4) leaves status, pending and output unchanged, and drives the error output high for one cycle.
- R8: A nonzero status write clears the written bits. If bits remain set, the output stays high.
- R9: A status write with every bit set clears status and leaves both the output and the pending word untouched.
- R10: Any other nonzero status write that leaves status at zero moves a nonzero pending word into status, empties pending and holds the output high. If pending is empty, it drives the output low.
- R11: A register write and an arrival in the same cycle are handled as if the write came first, so a newly enabled line that rises in that cycle is selected.
- R12: Reads at offset 0x0 return the stored enable value and reads at 0x4 return status. Reads at any other offset return zero, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | LINES | Interrupt source lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write byte offset |
| wr_data_i | input | LINES | Write data |
| rd_addr_i | input | ADDR_W | Read byte offset |
| rd_data_o | output | LINES | Read data (combinational) |
| irq_o | output | 1 | Aggregated interrupt output |
| clr_zero_err_o | output | 1 | One-cycle pulse on a zero status write |

## Verification
The bench builds the block with LINES = 8 and ADDR_W = 4. With an 8-bit word, the all-ones initialisation value is 0xFF, so both the init path and the ordinary partial clear can be reached with small constants. The narrow address lets the bench probe an unused offset (0x8) next to the two live registers. These values make every path reachable in a few dozen cycles: mask, then arrival, then unmask, then replay; pending held across an initialisation; and an enable that grows in the same cycle as a rising line.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;

  // Register selected by an address
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_STATUS = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/grp_irq_decode.sv
module grp_irq_decode
  import grp_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int ENA_OFS = 0,
  parameter int STS_OFS = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  localparam logic [ADDR_W-1:0] ENA_A = ADDR_W'(ENA_OFS);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFS);

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == ENA_A)      return SEL_ENABLE;
    else if (a == STS_A) return SEL_STATUS;
    else                 return SEL_NONE;
  endfunction

  always_comb sel_o = decode(addr_i);
endmodule

// File: rtl/grp_irq_edge.sv
module grp_irq_edge #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] src_i,
  output logic [LINES-1:0] rise_o,
  output logic             event_o
);
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_i;
  end

  always_comb begin
    rise_o  = src_i & ~prev_q;
    event_o = |rise_o;
  end

  // R2: an event always names at least one line that is high now
  p_event_has_high_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> (src_i != '0));
endmodule

// File: rtl/grp_irq_enable.sv
module grp_irq_enable #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [LINES-1:0] data_i,
  output logic [LINES-1:0] en_reg_o,
  output logic [LINES-1:0] acc_next_o,
  output logic [LINES-1:0] mask_next_o
);
  logic [LINES-1:0] reg_q, acc_q, mask_q;
  logic [LINES-1:0] reg_n, acc_n, mask_n;

  // Three-rule enable write: store-only, grow-enable, or mask/unmask
  function automatic void enable_write(
    input  logic [LINES-1:0] r, a, m, d,
    output logic [LINES-1:0] r_o, a_o, m_o);
    logic [LINES-1:0] chg;
    r_o = r; a_o = a; m_o = m;
    if (d == '0 && a == '0) begin
      r_o = d;
    end else if ((a | d) != a) begin
      a_o = a | d;
      r_o = d;
    end else begin
      chg = r ^ d;
      if ((chg & d) != '0) m_o = m & ~chg;
      else                 m_o = m | chg;
      r_o = d;
    end
  endfunction

  always_comb begin
    reg_n = reg_q; acc_n = acc_q; mask_n = mask_q;
    if (wr_i) enable_write(reg_q, acc_q, mask_q, data_i, reg_n, acc_n, mask_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q  <= '0;
      acc_q  <= '0;
      mask_q <= '0;
    end else begin
      reg_q  <= reg_n;
      acc_q  <= acc_n;
      mask_q <= mask_n;
    end
  end

  assign en_reg_o    = reg_q;
  assign acc_next_o  = acc_n;
  assign mask_next_o = mask_n;

  // R5: the accumulated enable word never loses a bit
  p_acc_only_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(acc_q) & ~acc_q) == '0));

  // R5: a write that grows the enable leaves the mask alone
  p_grow_keeps_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && ((acc_q | data_i) != acc_q)) |=> $stable(mask_q));

  // R6: without a write the mask cannot move
  p_mask_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_q) && $stable(reg_q));
endmodule

// File: rtl/grp_irq_status.sv
module grp_irq_status #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [LINES-1:0] data_i,
  input  logic             event_i,
  input  logic [LINES-1:0] select_i,
  input  logic [LINES-1:0] mask_i,
  output logic [LINES-1:0] status_o,
  output logic             irq_o,
  output logic             err_o
);
  localparam logic [LINES-1:0] ALL_ONES = '1;

  logic [LINES-1:0] status_q, pend_q;
  logic             irq_q, err_q;
  logic [LINES-1:0] st_w, pd_w;
  logic             irq_w, err_w;
  logic             arrival;

  // Acknowledge step: clear, then replay or drop the output
  function automatic void ack_write(
    input  logic [LINES-1:0] st, pd, d,
    input  logic             irq,
    output logic [LINES-1:0] st_o, pd_o,
    output logic             irq_o_f, bad_o);
    st_o = st; pd_o = pd; irq_o_f = irq; bad_o = 1'b0;
    if (d == '0) begin
      bad_o = 1'b1;
    end else begin
      st_o = st & ~d;
      if (d != ALL_ONES && st_o == '0) begin
        if (pd != '0) begin
          st_o    = pd;
          pd_o    = '0;
          irq_o_f = 1'b1;
        end else begin
          irq_o_f = 1'b0;
        end
      end
    end
  endfunction

  assign arrival = event_i && (select_i != '0);

  always_comb begin
    st_w = status_q; pd_w = pend_q; irq_w = irq_q; err_w = 1'b0;
    if (wr_i) ack_write(status_q, pend_q, data_i, irq_q, st_w, pd_w, irq_w, err_w);
    if (arrival) begin
      if (mask_i != '0 || st_w != '0) begin
        pd_w = pd_w | select_i;
      end else begin
        st_w  = select_i;
        irq_w = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      pend_q   <= '0;
      irq_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      status_q <= st_w;
      pend_q   <= pd_w;
      irq_q    <= irq_w;
      err_q    <= err_w;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;
  assign err_o    = err_q;

  // R3: any reported source keeps the output asserted
  p_status_drives_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q != '0) |-> irq_q);

  // R2: no write and no selected arrival leaves status and output alone
  p_quiet_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !arrival) |=> $stable(status_q) && $stable(irq_q));

  // R4: an arrival during service is deferred
  p_defer_keeps_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && arrival && (status_q != '0 || mask_i != '0))
      |=> $stable(status_q) && $stable(irq_q));

  // R7: zero acknowledge is refused and flagged
  p_zero_ack_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && data_i == '0 && !arrival)
      |=> $stable(status_q) && $stable(irq_q) && err_q);

  // R9: initialisation clears without touching the output
  p_init_no_replay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && data_i == ALL_ONES && !arrival)
      |=> (status_q == '0) && $stable(irq_q) && $stable(pend_q));
endmodule

// File: rtl/grp_irq_agg.sv
module grp_irq_agg
  import grp_irq_pkg::*;
#(
  parameter int LINES   = 32,
  parameter int ADDR_W  = 8,
  parameter int ENA_OFS = 0,
  parameter int STS_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LINES-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [LINES-1:0]  rd_data_o,
  output logic              irq_o,
  output logic              clr_zero_err_o
);
  reg_sel_e         wr_sel, rd_sel;
  logic             ena_wr, sts_wr;
  logic [LINES-1:0] rise, en_reg, acc_next, mask_next, select_word, status;
  logic             src_event;

  function automatic logic [LINES-1:0] select_of(
    input logic [LINES-1:0] lines, input logic [LINES-1:0] en);
    return lines & en;
  endfunction

  grp_irq_decode #(.ADDR_W(ADDR_W), .ENA_OFS(ENA_OFS), .STS_OFS(STS_OFS)) u_wr_dec (
    .addr_i(wr_addr_i), .sel_o(wr_sel));
  grp_irq_decode #(.ADDR_W(ADDR_W), .ENA_OFS(ENA_OFS), .STS_OFS(STS_OFS)) u_rd_dec (
    .addr_i(rd_addr_i), .sel_o(rd_sel));

  assign ena_wr = wr_en_i && (wr_sel == SEL_ENABLE);
  assign sts_wr = wr_en_i && (wr_sel == SEL_STATUS);

  grp_irq_edge #(.LINES(LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .rise_o(rise), .event_o(src_event));

  grp_irq_enable #(.LINES(LINES)) u_enable (
    .clk(clk), .rst_n(rst_n), .wr_i(ena_wr), .data_i(wr_data_i),
    .en_reg_o(en_reg), .acc_next_o(acc_next), .mask_next_o(mask_next));

  // R11: select uses the enable word after this cycle's write
  assign select_word = select_of(src_i, acc_next);

  grp_irq_status #(.LINES(LINES)) u_status (
    .clk(clk), .rst_n(rst_n), .wr_i(sts_wr), .data_i(wr_data_i),
    .event_i(src_event), .select_i(select_word), .mask_i(mask_next),
    .status_o(status), .irq_o(irq_o), .err_o(clr_zero_err_o));

  always_comb begin
    unique case (rd_sel)
      SEL_ENABLE: rd_data_o = en_reg;
      SEL_STATUS: rd_data_o = status;
      default:    rd_data_o = '0;
    endcase
  end

  // R12: a write to an unused offset leaves both registers alone
  p_stray_write_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel == SEL_NONE && !src_event)
      |=> $stable(status) && $stable(en_reg) && $stable(irq_o));

  // R2: rise detection is a subset of the lines
  p_rise_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise & ~src_i) == '0));
endmodule

// File: tb/sim_grp_irq_agg.sv
`timescale 1ns/1ps
module sim_grp_irq_agg;
  localparam int LINES  = 8;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_EN  = 4'h0;
  localparam logic [ADDR_W-1:0] A_STS = 4'h4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LINES-1:0]  src = '0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [LINES-1:0]  wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [LINES-1:0]  rd_data;
  logic              irq, err;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  grp_irq_agg #(.LINES(LINES), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq), .clr_zero_err_o(err));

  // Fields: kind[34:33] (0 write, 1 source level), addr[32:29], data[28:21],
  // exp irq[20], exp status[19:12], exp enable readback[11:4], requirement[3:0]
  localparam int NV = 23;
  localparam logic [34:0] VEC [NV] = '{
    {2'd0, 4'h0, 8'h00, 1'b0, 8'h00, 8'h00, 4'd5},   // R5 zero write, empty enable
    {2'd0, 4'h0, 8'h0F, 1'b0, 8'h00, 8'h0F, 4'd5},   // R5 grow enable
    {2'd1, 4'h0, 8'h01, 1'b1, 8'h01, 8'h0F, 4'd3},   // R3 first delivery
    {2'd1, 4'h0, 8'h03, 1'b1, 8'h01, 8'h0F, 4'd4},   // R4 deferred while status busy
    {2'd1, 4'h0, 8'h00, 1'b1, 8'h01, 8'h0F, 4'd2},   // R2 falling lines ignored
    {2'd0, 4'h4, 8'h01, 1'b1, 8'h03, 8'h0F, 4'd10},  // R10 replay pending
    {2'd0, 4'h4, 8'h02, 1'b1, 8'h01, 8'h0F, 4'd8},   // R8 partial clear
    {2'd0, 4'h4, 8'h01, 1'b0, 8'h00, 8'h0F, 4'd10},  // R10 empty pending drops irq
    {2'd1, 4'h0, 8'h10, 1'b0, 8'h00, 8'h0F, 4'd2},   // R2 disabled line ignored
    {2'd1, 4'h0, 8'h00, 1'b0, 8'h00, 8'h0F, 4'd2},
    {2'd0, 4'h0, 8'h0E, 1'b0, 8'h00, 8'h0E, 4'd6},   // R6 mask bit 0
    {2'd1, 4'h0, 8'h04, 1'b0, 8'h00, 8'h0E, 4'd4},   // R4 deferred while masked
    {2'd1, 4'h0, 8'h00, 1'b0, 8'h00, 8'h0E, 4'd2},
    {2'd0, 4'h0, 8'h0F, 1'b0, 8'h00, 8'h0F, 4'd6},   // R6 unmask bit 0
    {2'd1, 4'h0, 8'h08, 1'b1, 8'h08, 8'h0F, 4'd3},   // R3 delivery after unmask
    {2'd0, 4'h4, 8'h08, 1'b1, 8'h04, 8'h0F, 4'd10},  // R10 replay masked arrival
    {2'd1, 4'h0, 8'h0A, 1'b1, 8'h04, 8'h0F, 4'd4},   // R4 pend 0x0A
    {2'd0, 4'h4, 8'hFF, 1'b1, 8'h00, 8'h0F, 4'd9},   // R9 init keeps irq, no replay
    {2'd0, 4'h4, 8'h00, 1'b1, 8'h00, 8'h0F, 4'd7},   // R7 zero write refused
    {2'd1, 4'h0, 8'h09, 1'b1, 8'h09, 8'h0F, 4'd3},   // R3 delivery
    {2'd0, 4'h4, 8'h09, 1'b1, 8'h0A, 8'h0F, 4'd10},  // R9 pending survived init
    {2'd0, 4'h4, 8'h0A, 1'b0, 8'h00, 8'h0F, 4'd10},
    {2'd0, 4'h8, 8'hFF, 1'b0, 8'h00, 8'h0F, 4'd12}   // R12 stray write ignored
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic read_reg(input logic [ADDR_W-1:0] a, output logic [LINES-1:0] v);
    rd_addr = a;
    #0.4;
    v = rd_data;
  endtask

  // Apply one operation at a falling edge; results are sampled at the next one
  task automatic apply(input logic [1:0] kind, input logic [ADDR_W-1:0] a,
                       input logic [LINES-1:0] d);
    @(negedge clk);
    if (kind == 2'd0) begin
      wr_en = 1'b1; wr_addr = a; wr_data = d;
    end else begin
      src = d;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_state(input int req, input logic [LINES-1:0] e_sts,
                             input logic e_irq, input logic [LINES-1:0] e_en);
    logic [LINES-1:0] v;
    read_reg(A_STS, v);
    check(req, 32'(v), 32'(e_sts), "status");
    check(req, 32'(irq), 32'(e_irq), "irq");
    read_reg(A_EN, v);
    check(req, 32'(v), 32'(e_en), "enable");
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [LINES-1:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_state(1, 8'h00, 1'b0, 8'h00);
    check(1, 32'(err), 0, "err");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][34:33], VEC[i][32:29], VEC[i][28:21]);
      check_state(int'(VEC[i][3:0]), VEC[i][19:12], VEC[i][20], VEC[i][11:4]);
    end

    // R12: unused offset reads zero
    read_reg(4'h8, v);
    check(12, 32'(v), 0, "stray read");

    // R11: enable grows in the same cycle bit 5 rises (src currently 0x09)
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_EN; wr_data = 8'h3F; src = 8'h29;
    @(negedge clk);
    wr_en = 1'b0;
    check_state(11, 8'h29, 1'b1, 8'h3F);

    // R7: zero status write raises the error pulse for one cycle
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_STS; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    check(7, 32'(err), 1, "err pulse");
    check_state(7, 8'h29, 1'b1, 8'h3F);
    @(negedge clk);
    check(7, 32'(err), 0, "err pulse end");

    // R1: mid-run reset clears everything, including enable and mask
    src = 8'h00;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_state(1, 8'h00, 1'b0, 8'h00);
    rst_n = 1'b1;
    apply(2'd1, 4'h0, 8'h01);
    check_state(1, 8'h00, 1'b0, 8'h00);  // enable empty after reset
    apply(2'd1, 4'h0, 8'h00);
    apply(2'd0, A_EN, 8'h01);
    apply(2'd1, 4'h0, 8'h01);
    check_state(1, 8'h01, 1'b1, 8'h01);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule